// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a synchronous requester and an external asynchronous static RAM. The RAM is 128K words of 8 bits and has two chip selects of opposite polarity. The requester raises `req` for one word, either a read or a write, while the controller is idle. The controller then drives the RAM's select, output-enable and write strobe in a fixed order, holding each phase for a whole number of clock cycles. It returns a one-cycle `done` pulse. For a read, `done` comes with the captured byte on `rdata`.

The RAM's timing minimums are given in nanoseconds. They are turned into cycle counts, rounded up, from the clock period and a speed-grade parameter:

- Grade 0 is the faster part (70 ns cycle).
- Grade 1 is the slower part (85 ns cycle).

A single down-counter times every phase.

The machine has six states:

- `ST_IDLE`: RAM in standby.
- `ST_RD_ACCESS`: select and output enable low.
- `ST_RD_TURN`: bus release after a read.
- `ST_WR_SETUP`: select low, data driven, strobe still high.
- `ST_WR_STROBE`: write strobe low.
- `ST_WR_RECOVER`: strobe high, data still driven.

The transitions are:

- IDLE→RD_ACCESS on a read request.
- IDLE→WR_SETUP on a write request.
- RD_ACCESS→RD_TURN when the access count expires; the data is captured on that edge.
- RD_TURN→IDLE when the turnaround count expires.
- WR_SETUP→WR_STROBE after one cycle.
- WR_STROBE→WR_RECOVER when the strobe count expires.
- WR_RECOVER→IDLE when the recovery count expires.

Top module: `sram_async_ctrl`

## Requirements
The cycle counts below are for the defaults: grade 0 and a 20 ns clock.

- R1: While `rst_n` is low, the pins are `mem_ce_n`=1, `mem_ce`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `done`=0. From the first clock edge after reset is released, `mem_ce` is 1.
- R2: In idle, the pins are `mem_ce_n`=1, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `done`=0, except for a write's `done` cycle (R6).
- R3: A read is accepted on the edge where the block is idle, `req`=1 and `req_we`=0. For the next 4 cycles the pins are `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0.
- R4: On the edge that ends the 4th access cycle, `rdata` takes the value of `mem_dq_in`. `done` is 1 for exactly the cycle after that edge. `rdata` holds its value until the next read completes.
- R5: After a read there are 2 cycles with `mem_ce_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0, with `done` in the first of them. Only then does the block return to idle.
- R6: A write (`req_we`=1) runs in this order:
  - 1 setup cycle: `mem_ce_n`=0, `mem_we_n`=1, `mem_dq_oe`=1.
  - 3 strobe cycles: `mem_we_n`=0.
  - 1 recovery cycle: `mem_ce_n`=0, `mem_we_n`=1, `mem_dq_oe`=1.
  - `mem_dq_out` equals the request's data throughout.
  - `done` is 1 in the idle cycle that follows, and a new request is accepted on the edge ending that cycle.
- R7: `mem_oe_n` is high for the whole of a write. `mem_oe_n` and `mem_we_n` are never low together, and the data drivers are on only while `mem_oe_n` is high.
- R8: While `mem_ce_n` is low, `mem_addr` is stable and equals the request's address.
- R9: A `req` raised while the block is not idle is ignored. The pin sequence under way is unchanged and no extra access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, sampled when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last captured read byte |
| mem_addr | output | 17 | RAM address bus |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | 8 | Data toward the RAM |
| mem_dq_in | input | 8 | Data from the RAM |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |

## Verification
A wrong state or a miscounted phase timer shows on the RAM pins in the very cycle it happens. Examples are a strobe that is one cycle short, a select released early, or output enable dropping while the drivers are on. Each cycle's pins are compared with a sequence built from the requirements, so such a fault is reported at once. A bad capture edge, or a lost data latch, shows on `rdata` the first cycle after `done`, once the read-back value differs from what the bench's own memory holds. Requests raised while the block is busy are made on purpose, so a spurious acceptance breaks the expected sequence on the next edge.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_TURN,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_RECOVER
    } sram_state_e;

    // Ceiling of ns / period: a minimum time becomes whole clock cycles.
    function automatic int ns_to_cycles(int ns, int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (cap_en)
            dout <= din;
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int SPEED_GRADE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam bit SLOW = (SPEED_GRADE != 0);
    localparam int T_CYCLE_NS = SLOW ? 85 : 70;  // read/write cycle and address access
    localparam int T_OE_NS    = SLOW ? 45 : 35;
    localparam int T_WP_NS    = SLOW ? 60 : 50;
    localparam int T_CW_NS    = SLOW ? 75 : 60;
    localparam int T_DS_NS    = SLOW ? 35 : 30;
    localparam int T_OFF_NS   = SLOW ? 30 : 25;  // worst bus release after deselect

    localparam int RD_CYC   = imax(ns_to_cycles(T_CYCLE_NS, CLK_PERIOD_NS),
                                   ns_to_cycles(T_OE_NS, CLK_PERIOD_NS));
    localparam int STB_CYC  = imax(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                                   imax(ns_to_cycles(T_CW_NS, CLK_PERIOD_NS),
                                        ns_to_cycles(T_DS_NS, CLK_PERIOD_NS)));
    localparam int REC_CYC  = imax(1, ns_to_cycles(T_CYCLE_NS, CLK_PERIOD_NS) - 1 - STB_CYC);
    localparam int TURN_CYC = imax(1, ns_to_cycles(T_OFF_NS, CLK_PERIOD_NS));
    localparam int MAX_CYC  = imax(imax(RD_CYC, STB_CYC), imax(REC_CYC, TURN_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    sram_state_e       state, state_nx;
    logic              tmr_load, tmr_done, cap_en;
    logic [CNT_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              done_q, ce_hi_q;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .din    (mem_dq_in),
        .dout   (rdata)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Request latch, completion pulse and high-side select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
            ce_hi_q <= 1'b0;
        end else begin
            ce_hi_q <= 1'b1;
            done_q  <= tmr_done && (state == ST_RD_ACCESS || state == ST_WR_RECOVER);
            if (state == ST_IDLE && req) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    // Next state and phase timer loads
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_en   = 1'b0;
        unique case (state)
            ST_IDLE: if (req) begin
                tmr_load = 1'b1;
                if (req_we) begin
                    state_nx = ST_WR_SETUP;
                end else begin
                    state_nx = ST_RD_ACCESS;
                    tmr_val  = CNT_W'(RD_CYC - 1);
                end
            end
            ST_RD_ACCESS: if (tmr_done) begin
                cap_en   = 1'b1;
                state_nx = ST_RD_TURN;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(TURN_CYC - 1);
            end
            ST_RD_TURN: if (tmr_done) state_nx = ST_IDLE;
            ST_WR_SETUP: if (tmr_done) begin
                state_nx = ST_WR_STROBE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(STB_CYC - 1);
            end
            ST_WR_STROBE: if (tmr_done) begin
                state_nx = ST_WR_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(REC_CYC - 1);
            end
            ST_WR_RECOVER: if (tmr_done) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Pin decode from the registered state
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state)
            ST_IDLE, ST_RD_TURN: ;
            ST_RD_ACCESS: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            ST_WR_SETUP, ST_WR_RECOVER: begin
                mem_ce_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_STROBE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign mem_ce     = ce_hi_q;
    assign done       = done_q;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr
);
    assert_ce_hi_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> mem_ce);

    assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

    assert_read_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> !mem_dq_oe ##1 !mem_dq_oe);

    assert_no_oe_we_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    assert_drive_with_oe_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .mem_ce_n  (mem_ce_n),
    .mem_ce    (mem_ce),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr)
);

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;
    localparam int RD_N = 4, TURN_N = 2, STB_N = 3, REC_N = 1;  // R3 R5 R6 counts

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_we = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        done;
    logic [7:0]  rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    always #10 clk = ~clk;

    sram_async_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    // Behavioural RAM driven only by the pins
    logic [7:0] sram [int];
    logic [7:0] ref_mem [int];

    function automatic logic [7:0] blank(logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'h1E, a[16]};
    endfunction

    always @(posedge mem_we_n)
        if (rst_n && !mem_ce_n && mem_ce && mem_dq_oe)
            sram[int'(mem_addr)] = mem_dq_out;

    always @(mem_addr, mem_ce_n, mem_ce, mem_oe_n, mem_we_n) begin
        if (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n)
            mem_dq_in = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : blank(mem_addr);
        else
            mem_dq_in = 8'h00;
    end

    // Reference model: one expected pin set per cycle
    typedef struct {
        bit          idle;
        bit          ce_n, oe_n, we_n, dq_oe, dn;
        bit          chk_a;
        logic [16:0] a;
        bit          chk_d;
        logic [7:0]  d;
        bit          set_rd;
        logic [7:0]  rd;
        int          tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0, errors = 0;
    bit   finished = 1'b0;

    task automatic chk(bit ok, string req_tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h at %0t", req_tag, what, act, expv, $time);
        end
    endtask

    function automatic exp_t mk(bit idle, bit ce_n, bit oe_n, bit we_n, bit dq_oe, bit dn, int tag);
        exp_t e;
        e.idle = idle; e.ce_n = ce_n; e.oe_n = oe_n; e.we_n = we_n; e.dq_oe = dq_oe;
        e.dn = dn; e.chk_a = 0; e.a = '0; e.chk_d = 0; e.d = '0; e.set_rd = 0; e.rd = '0;
        e.tag = tag;
        return e;
    endfunction

    task automatic push_read(logic [16:0] a);
        exp_t e;
        for (int i = 0; i < RD_N; i++) begin
            e = mk(0, 0, 0, 1, 0, 0, 3);  // R3 access cycles
            e.chk_a = 1; e.a = a;
            exp_q.push_back(e);
        end
        e = mk(0, 1, 1, 1, 0, 1, 5);      // R5 turnaround, done per R4
        e.set_rd = 1;
        e.rd = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : blank(a);
        exp_q.push_back(e);
        for (int i = 1; i < TURN_N; i++) exp_q.push_back(mk(0, 1, 1, 1, 0, 0, 5));
    endtask

    task automatic push_write(logic [16:0] a, logic [7:0] d);
        exp_t e;
        e = mk(0, 0, 1, 1, 1, 0, 6); e.chk_a = 1; e.a = a; e.chk_d = 1; e.d = d;
        exp_q.push_back(e);
        for (int i = 0; i < STB_N; i++) begin
            e.we_n = 0; exp_q.push_back(e);
        end
        e.we_n = 1;
        for (int i = 0; i < REC_N; i++) exp_q.push_back(e);
        exp_q.push_back(mk(1, 1, 1, 1, 0, 1, 6));  // R6 done in idle
        ref_mem[int'(a)] = d;
    endtask

    function automatic string tname(int t);
        case (t)
            2: return "R2";
            3: return "R3";
            5: return "R5";
            6: return "R6";
            default: return "R9";
        endcase
    endfunction

    logic [16:0] pool [8];
    initial begin
        pool[0] = 17'h00000; pool[1] = 17'h1FFFF; pool[2] = 17'h00001; pool[3] = 17'h10000;
        pool[4] = 17'h0AAAA; pool[5] = 17'h15555; pool[6] = 17'h00FF0; pool[7] = 17'h1F00F;
    end

    logic [7:0] exp_rdata = '0;
    bit         rd_valid = 0;

    initial begin : main
        exp_t e;
        bit   junk = 0;
        int   op = 0;
        string tg;
        // R1: reset values
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe && !done,
                "R1", "reset pins {ce_n,ce,oe_n,we_n,dq_oe,done}",
                {mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe, done}, 6'b101100);
        end
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            e = (exp_q.size() != 0) ? exp_q.pop_front() : mk(1, 1, 1, 1, 0, 0, 2);
            tg = junk && !e.idle ? {tname(e.tag), "/R9"} : tname(e.tag);
            chk(mem_ce, "R1", "mem_ce after reset", mem_ce, 1);
            chk(mem_ce_n == e.ce_n, tg, "mem_ce_n", mem_ce_n, e.ce_n);
            chk(mem_oe_n == e.oe_n, e.tag == 6 ? "R7" : tg, "mem_oe_n", mem_oe_n, e.oe_n);
            chk(mem_we_n == e.we_n, tg, "mem_we_n", mem_we_n, e.we_n);
            chk(mem_dq_oe == e.dq_oe, tg, "mem_dq_oe", mem_dq_oe, e.dq_oe);
            chk(done == e.dn, e.tag == 6 ? "R6" : "R4", "done", done, e.dn);
            chk(!(!mem_oe_n && !mem_we_n), "R7", "oe_n/we_n overlap", {mem_oe_n, mem_we_n}, 2'b11);
            if (e.chk_a) chk(mem_addr == e.a, "R8", "mem_addr", mem_addr, e.a);
            if (e.chk_d) chk(mem_dq_out == e.d, "R6", "mem_dq_out", mem_dq_out, e.d);
            if (e.set_rd) begin exp_rdata = e.rd; rd_valid = 1; end
            if (rd_valid) chk(rdata == exp_rdata, "R4", "rdata", rdata, exp_rdata);
            // stimulus for the coming edge
            junk = 0;
            if (e.idle) begin
                if (op < 6) begin
                    req = 1'b1;
                    case (op)
                        0: begin req_we = 1; req_addr = 17'h00000; req_wdata = 8'hFF; end
                        1: begin req_we = 0; req_addr = 17'h00000; end
                        2: begin req_we = 1; req_addr = 17'h1FFFF; req_wdata = 8'h00; end
                        3: begin req_we = 0; req_addr = 17'h1FFFF; end
                        4: begin req_we = 0; req_addr = 17'h0AAAA; end
                        default: begin req_we = 1; req_addr = 17'h0AAAA; req_wdata = 8'h5A; end
                    endcase
                    op++;
                end else begin
                    req = ($urandom_range(0, 9) < 6);
                    req_we = $urandom_range(0, 1) == 1;
                    req_addr = pool[$urandom_range(0, 7)];
                    req_wdata = 8'($urandom);
                end
                if (req) begin
                    if (req_we) push_write(req_addr, req_wdata);
                    else push_read(req_addr);
                end
            end else begin
                req = $urandom_range(0, 1) == 1;  // R9: must be ignored
                junk = req;
                req_we = $urandom_range(0, 1) == 1;
                req_addr = pool[$urandom_range(0, 7)];
                req_wdata = 8'($urandom);
            end
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule